// File: doc/BRIEF.md
# Per-Pin I/O Control Bank with LED Blinker and Edge Interrupts

This block controls one port of up to eight general-purpose pins from a byte-wide register bus. Each pin owns one control byte. That byte holds the pin's direction, its output data and a 3-bit function code. The meaning of the function code depends on the direction. On an output pin it picks a steady level or one of seven blink rates, for driving an LED that is tied to the supply (active low). On an input pin it picks which filtered edge raises an interrupt.

Two port-wide registers give parallel access to all direction bits and all data bits at once. They use the same flops as the per-pin bytes, so a write through either path is seen through the other. Input levels pass through a synchroniser and a transition filter. A qualified edge is queued, and its control-byte address is placed in a status register while an active-low interrupt line is driven. Reading the status register empties it and releases the line. Any further pending pin is then reported, lowest pin number first.

Top module: `pin_ctl_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `int_n` is 1, every per-pin byte reads function 000 with direction 1, and the status register reads 00h.
- R2: Pin i's control byte is at address 80h+i. Its fields are: bits 4:2 the function code, bit 1 the direction, bit 0 the data. Bits 7:5 read as 0.
- R3: Direction 1 makes a pin an input (`pin_oe`=0). Direction 0 makes it an output (`pin_oe`=1).
- R4: The port-wide direction register sits at 88h and the port-wide data register at 89h, with bit i belonging to pin i. They share storage with the per-pin bits, so a write on either path is visible on the other.
- R5: A read returns the synchronised pin level in the data bit (bit 0 of a per-pin byte, and every bit of 89h), never the latched output value.
- R6: An output pin with function 000 drives its data bit steadily on `pin_out`.
- R7: An output pin with function code c in 1..7 toggles `pin_out` every 2^(BLINK_BASE+c-2) clocks, which is a full period of the clock divided by 2^(BLINK_BASE+c-1).
- R8: For an input pin the function code selects the interrupting edge: 001 rising, 010 falling, 011 both, 000 none. Codes 1xx act like 000.
- R9: A level change counts as an edge only after the synchronised level has differed from the filtered level for 3 consecutive clocks. A shorter pulse is ignored.
- R10: A qualified edge pulls `int_n` low and loads the status register at 8Ah with the pin's control-byte address (80h+i).
- R11: Reading 8Ah returns the status and clears it, releasing `int_n`. If further edges are pending, the lowest-numbered pin is loaded on the next clock.
- R12: No edge is qualified while a pin is an output, nor on the clock where its direction bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the clock after `rd_en` |
| pin_in | input | NPINS | Sampled pad levels |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output enable per pin, 1 = drive |
| int_n | output | 1 | Interrupt request, active low |

## Verification
Read data is registered, so every read is compared at the falling edge one clock after the rising edge that took `rd_en`. Register writes show on `pin_oe` and `pin_out` at the falling edge straight after the write edge. A pin change takes two synchroniser clocks and three filter clocks, and one more clock reaches the status register. The bench therefore confirms that `int_n` is still high at the falling edge after the fifth rising edge following the change, and low after the sixth. Blink rates are checked by counting transitions over windows that are whole multiples of the half-period, which makes the check independent of the prescaler's phase.

// File: rtl/pin_ctl_pkg.sv
package pin_ctl_pkg;

   localparam int FS_W = 3;
   typedef logic [FS_W-1:0] fsel_t;

   // function codes as seen by an input pin
   localparam fsel_t FS_NONE = 3'b000;
   localparam fsel_t FS_RISE = 3'b001;
   localparam fsel_t FS_FALL = 3'b010;
   localparam fsel_t FS_BOTH = 3'b011;

   // number of blink taps selectable on an output pin
   localparam int N_RATES = 7;

   function automatic logic edge_hit(fsel_t fs, logic rise, logic fall);
      logic r;
      case (fs)
         FS_RISE: r = rise;
         FS_FALL: r = fall;
         FS_BOTH: r = rise | fall;
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pin_ctl_regs.sv
module pin_ctl_regs
   import pin_ctl_pkg::*;
#(
   parameter int          NPINS     = 8,
   parameter logic [7:0]  BASE_ADDR = 8'h80
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        addr,
   input  logic [7:0]        wdata,
   input  logic [NPINS-1:0]  pin_lvl,
   input  logic [7:0]        stat_byte,
   output logic [7:0]        rdata,
   output fsel_t [NPINS-1:0] fs_o,
   output logic [NPINS-1:0]  dir_o,
   output logic [NPINS-1:0]  dat_o
);

   localparam logic [7:0] DIR_A  = 8'(BASE_ADDR + NPINS);
   localparam logic [7:0] DATA_A = 8'(BASE_ADDR + NPINS + 1);
   localparam logic [7:0] STAT_A = 8'(BASE_ADDR + NPINS + 2);

   fsel_t [NPINS-1:0] fs_q;
   logic  [NPINS-1:0] dir_q, dat_q;
   logic  [7:0]       rd_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q  <= '0;
         dir_q <= '1;
         dat_q <= '1;
      end else if (wr_en) begin
         for (int i = 0; i < NPINS; i++) begin
            if (addr == 8'(BASE_ADDR + i)) begin
               fs_q[i]  <= wdata[4:2];
               dir_q[i] <= wdata[1];
               dat_q[i] <= wdata[0];
            end
         end
         if (addr == DIR_A)  dir_q <= wdata[NPINS-1:0];
         if (addr == DATA_A) dat_q <= wdata[NPINS-1:0];
      end
   end

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NPINS; i++) begin
         if (addr == 8'(BASE_ADDR + i))
            rd_next = {3'b000, fs_q[i], dir_q[i], pin_lvl[i]};
      end
      if (addr == DIR_A)  rd_next[NPINS-1:0] = dir_q;
      if (addr == DATA_A) rd_next[NPINS-1:0] = pin_lvl;
      if (addr == STAT_A) rd_next = stat_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   assign fs_o  = fs_q;
   assign dir_o = dir_q;
   assign dat_o = dat_q;

endmodule

// File: rtl/pin_ctl_filt.sv
module pin_ctl_filt #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic lvl,
   output logic rise,
   output logic fall
);

   localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       cnt_q;
   logic                   filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
   end

   assign lvl = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         filt_q <= 1'b1;
         rise   <= 1'b0;
         fall   <= 1'b0;
      end else begin
         rise <= 1'b0;
         fall <= 1'b0;
         if (lvl == filt_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
            cnt_q  <= '0;
            filt_q <= lvl;
            rise   <= lvl;
            fall   <= ~lvl;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pin_ctl_blink.sv
module pin_ctl_blink
   import pin_ctl_pkg::*;
#(
   parameter int NPINS      = 8,
   parameter int BLINK_BASE = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  fsel_t [NPINS-1:0] fs,
   input  logic [NPINS-1:0]  dir,
   input  logic [NPINS-1:0]  dat,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe
);

   localparam int PW = BLINK_BASE + N_RATES - 1;

   logic [PW-1:0] presc_q;
   logic [7:0]    tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) presc_q <= '0;
      else        presc_q <= presc_q + 1'b1;
   end

   assign tap[0] = 1'b0;
   for (genvar k = 1; k <= N_RATES; k++) begin : g_tap
      assign tap[k] = presc_q[BLINK_BASE + k - 2];
   end

   always_comb begin
      for (int i = 0; i < NPINS; i++)
         pin_out[i] = (fs[i] == FS_NONE) ? dat[i] : tap[fs[i]];
   end

   assign pin_oe = ~dir;

endmodule

// File: rtl/pin_ctl_irq.sv
module pin_ctl_irq
   import pin_ctl_pkg::*;
#(
   parameter int         NPINS     = 8,
   parameter logic [7:0] BASE_ADDR = 8'h80
)(
   input  logic              clk,
   input  logic              rst_n,
   input  fsel_t [NPINS-1:0] fs,
   input  logic [NPINS-1:0]  dir,
   input  logic [NPINS-1:0]  rise,
   input  logic [NPINS-1:0]  fall,
   input  logic              stat_rd,
   output logic [7:0]        stat_byte,
   output logic              int_n,
   output logic              pend_any
);

   logic [NPINS-1:0] dir_q, pend_q, hit, cand, take_mask;
   logic             valid_q, found;
   logic [7:0]       stat_q, sel_addr;

   always_comb begin
      for (int i = 0; i < NPINS; i++)
         hit[i] = dir[i] & dir_q[i] & edge_hit(fs[i], rise[i], fall[i]);
   end

   assign cand = pend_q | hit;

   always_comb begin
      found     = 1'b0;
      sel_addr  = '0;
      take_mask = '0;
      for (int i = 0; i < NPINS; i++) begin
         if (cand[i] && !found) begin
            found        = 1'b1;
            sel_addr     = 8'(BASE_ADDR + i);
            take_mask[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '1;
         pend_q  <= '0;
         valid_q <= 1'b0;
         stat_q  <= '0;
      end else begin
         dir_q <= dir;
         if (!valid_q && found) begin
            valid_q <= 1'b1;
            stat_q  <= sel_addr;
            pend_q  <= cand & ~take_mask;
         end else begin
            pend_q <= cand;
            if (valid_q && stat_rd) begin
               valid_q <= 1'b0;
               stat_q  <= '0;
            end
         end
      end
   end

   assign stat_byte = stat_q;
   assign int_n     = ~valid_q;
   assign pend_any  = |pend_q;

endmodule

// File: rtl/pin_ctl_bank.sv
module pin_ctl_bank
   import pin_ctl_pkg::*;
#(
   parameter int         NPINS       = 8,
   parameter logic [7:0] BASE_ADDR   = 8'h80,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   parameter int         BLINK_BASE  = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             int_n
);

   localparam logic [7:0] STAT_A = 8'(BASE_ADDR + NPINS + 2);

   if (NPINS < 1 || NPINS > 8) begin : g_bad_npins
      $error("NPINS must lie in 1..8");
   end
   if (int'(BASE_ADDR) + NPINS + 2 > 255) begin : g_bad_base
      $error("register window exceeds the 8-bit address space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("FILT_LEN must be at least 2");
   end
   if (BLINK_BASE < 2) begin : g_bad_blink
      $error("BLINK_BASE must be at least 2");
   end

   fsel_t [NPINS-1:0] fs;
   logic [NPINS-1:0]  dir, dat, pin_lvl, rise_p, fall_p;
   logic [7:0]        stat_byte;
   logic              stat_rd, pend_any;

   assign stat_rd = rd_en && (addr == STAT_A);

   pin_ctl_regs #(.NPINS(NPINS), .BASE_ADDR(BASE_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .pin_lvl(pin_lvl), .stat_byte(stat_byte), .rdata(rdata),
      .fs_o(fs), .dir_o(dir), .dat_o(dat)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pin_ctl_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
         .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
         .lvl(pin_lvl[i]), .rise(rise_p[i]), .fall(fall_p[i])
      );
   end

   pin_ctl_blink #(.NPINS(NPINS), .BLINK_BASE(BLINK_BASE)) u_blink (
      .clk(clk), .rst_n(rst_n), .fs(fs), .dir(dir), .dat(dat),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   pin_ctl_irq #(.NPINS(NPINS), .BASE_ADDR(BASE_ADDR)) u_irq (
      .clk(clk), .rst_n(rst_n), .fs(fs), .dir(dir), .rise(rise_p),
      .fall(fall_p), .stat_rd(stat_rd), .stat_byte(stat_byte),
      .int_n(int_n), .pend_any(pend_any)
   );

endmodule

// File: rtl/pin_ctl_bank_chk.sv
module pin_ctl_bank_chk #(
   parameter int         NPINS     = 8,
   parameter logic [7:0] BASE_ADDR = 8'h80
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [7:0]       addr,
   input logic [7:0]       wdata,
   input logic [7:0]       rdata,
   input logic [NPINS-1:0] pin_oe,
   input logic             int_n,
   input logic [NPINS-1:0] rise_p,
   input logic [NPINS-1:0] fall_p,
   input logic             pend_any
);

   localparam logic [7:0] DIR_A  = 8'(BASE_ADDR + NPINS);
   localparam logic [7:0] STAT_A = 8'(BASE_ADDR + NPINS + 2);
   localparam logic [8:0] PIN_HI = 9'(BASE_ADDR + NPINS);

   // R2
   hi_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr >= BASE_ADDR && {1'b0, addr} < PIN_HI) |=> (rdata[7:5] == 3'b000));

   // R4
   port_dir_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == DIR_A) |=> (pin_oe == ~$past(wdata[NPINS-1:0])));

   // R11
   stat_read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == STAT_A && !int_n) |=> int_n);

   // R10
   irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> $past(pend_any || (|(rise_p | fall_p))));

   // R9
   edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise_p | fall_p)) |=> ((rise_p | fall_p) & $past(rise_p | fall_p)) == '0);

endmodule

bind pin_ctl_bank pin_ctl_bank_chk #(.NPINS(NPINS), .BASE_ADDR(BASE_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .pin_oe(pin_oe), .int_n(int_n),
   .rise_p(rise_p), .fall_p(fall_p), .pend_any(pend_any)
);

// File: tb/pin_ctl_bank_test.sv
`timescale 1ns/1ps
module pin_ctl_bank_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic [7:0] rdata;
   logic [7:0] pin_in = 8'hFF;
   logic [7:0] pin_out, pin_oe;
   logic       int_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   typedef struct { logic [7:0] exp; string tag; } rd_item_t;
   rd_item_t rq[$];
   logic rd_q = 1'b0;

   always #2 clk = ~clk;

   pin_ctl_bank #(.BLINK_BASE(2)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .int_n(int_n)
   );

   task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares registered read data one clock after the read edge
   always @(posedge clk) rd_q <= rd_en;
   always @(negedge clk) begin
      if (rd_q) begin
         rd_item_t it;
         if (rq.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL monitor: unexpected read data %h, expected none", rdata);
         end else begin
            it = rq.pop_front();
            chk(rdata, it.exp, it.tag);
         end
      end
   end

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
      rd_item_t it;
      it.exp = exp; it.tag = tag;
      @(negedge clk); rd_en = 1'b1; addr = a; rq.push_back(it);
      @(negedge clk); rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_toggles(int intervals, int pin, int exp, string tag);
      int t = 0;
      logic prev;
      @(negedge clk); prev = pin_out[pin];
      for (int k = 0; k < intervals; k++) begin
         @(negedge clk);
         if (pin_out[pin] !== prev) t++;
         prev = pin_out[pin];
      end
      chk(8'(t), 8'(exp), tag);
   endtask

   initial begin
      #(4ns * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pin_oe, 8'h00, "R1 pin_oe after reset");
      chk({7'b0, int_n}, 8'h01, "R1 int_n after reset");
      rd(8'h80, 8'h03, "R1 R2 pin0 byte after reset");
      rd(8'h87, 8'h03, "R1 pin7 byte after reset");
      rd(8'h8A, 8'h00, "R1 status after reset");
      rd(8'h88, 8'hFF, "R4 port dir after reset");
      rd(8'h89, 8'hFF, "R5 port level after reset");

      // R3 R4 port-wide direction seen per pin
      wr(8'h88, 8'hF0);
      chk(pin_oe, 8'h0F, "R3 pins 0-3 become outputs");
      rd(8'h81, 8'h01, "R4 pin1 byte shows port dir");

      // R6 steady drive, R5 readback is pin level
      wr(8'h89, 8'h00);
      chk({4'h0, pin_out[3:0]}, 8'h00, "R6 steady low from port data");
      rd(8'h89, 8'hFF, "R5 data read is pin level");
      wr(8'h82, 8'h01);
      chk({4'h0, pin_out[3:0]}, 8'h04, "R4 R6 per-pin data on pin2");
      rd(8'h88, 8'hF0, "R4 port dir unchanged by pin write");
      pin_in[1] = 1'b0; idle(4);
      rd(8'h81, 8'h00, "R5 pin1 level low, not latch");
      pin_in[1] = 1'b1; idle(4);

      // R7 blink rates, BLINK_BASE = 2
      wr(8'h83, 8'h04);
      count_toggles(8, 3, 4, "R7 code1 toggles every 2");
      wr(8'h83, 8'h0C);
      count_toggles(16, 3, 2, "R7 code3 toggles every 8");
      wr(8'h83, 8'h1C);
      count_toggles(256, 3, 2, "R7 code7 toggles every 128");
      chk({7'b0, pin_oe[3]}, 8'h01, "R3 blinking pin drives");

      // R10 rising edge on pin6 with exact latency
      pin_in[6] = 1'b0; idle(10);
      wr(8'h86, 8'h06);
      idle(2);
      @(negedge clk); pin_in[6] = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk({7'b0, int_n}, 8'h01, "R9 R10 int_n still high at 5 edges");
      @(negedge clk);
      chk({7'b0, int_n}, 8'h00, "R10 int_n low at 6 edges");
      rd(8'h8A, 8'h86, "R10 status holds pin6 address");
      chk({7'b0, int_n}, 8'h01, "R11 int_n released after read");
      rd(8'h8A, 8'h00, "R11 status cleared");

      // R8 falling edge ignored under rising code
      pin_in[6] = 1'b0; idle(12);
      chk({7'b0, int_n}, 8'h01, "R8 fall ignored on rise code");

      // R9 short glitch ignored
      wr(8'h87, 8'h0E);
      idle(2);
      @(negedge clk); pin_in[7] = 1'b0;
      idle(2); pin_in[7] = 1'b1;
      idle(12);
      chk({7'b0, int_n}, 8'h01, "R9 two-clock glitch ignored");
      pin_in[7] = 1'b0; idle(12);
      rd(8'h8A, 8'h87, "R8 both-edge code catches fall");

      // R8 reserved code
      wr(8'h87, 8'h12);
      idle(2);
      pin_in[7] = 1'b1; idle(12);
      chk({7'b0, int_n}, 8'h01, "R8 reserved code no interrupt");

      // R11 two pending, lowest first
      wr(8'h84, 8'h0A);
      wr(8'h85, 8'h0E);
      idle(2);
      pin_in[4] = 1'b0; pin_in[5] = 1'b0; idle(12);
      chk({7'b0, int_n}, 8'h00, "R10 int_n low for pins 4 and 5");
      rd(8'h8A, 8'h84, "R11 lowest pin reported first");
      chk({7'b0, int_n}, 8'h00, "R11 next pending reasserts");
      rd(8'h8A, 8'h85, "R11 second pin reported");
      rd(8'h8A, 8'h00, "R11 queue empty");
      chk({7'b0, int_n}, 8'h01, "R11 int_n high when empty");

      // R12 output pin never interrupts
      wr(8'h80, 8'h04);
      idle(2);
      pin_in[0] = 1'b0; idle(12);
      pin_in[0] = 1'b1; idle(12);
      chk({7'b0, int_n}, 8'h01, "R12 output pin edge ignored");

      idle(4);
      done = 1;
      if (rq.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: got %0d leftover reads expected 0", rq.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule